// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current of one winding through a full H-bridge. In the on-time it closes one diagonal of the bridge. Which diagonal it closes depends on the requested polarity. When the external current comparator reports that the trip level has been reached, the controller opens the bridge for a fixed number of clock cycles and then starts a new on-time. During that off-time the winding current decays in one of two ways:

- **Slow decay:** both low-side switches conduct.
- **Mixed decay:** a fast-decay interval comes first, in which the opposite diagonal conducts, and the rest of the off-time is slow decay.

The caller selects the decay style through a flag. The flag is sampled at the moment of the trip.

Switching edges cause false comparator trips, so the comparator is ignored for a programmable blanking interval after every state change. A trip that arrives during blanking is discarded. Each half-bridge leg enforces a dead time before a switch may close after its partner in the same leg has opened. A zero-current indication during the off-time opens every switch until the next on-time, so that synchronous rectification cannot drive the current backwards. Dropping the output enable opens every gate at once and returns the controller to idle.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is high, all four gate outputs are 0.
- R2: On-time closes one diagonal of the bridge. With polarity 1 it closes the high switch of leg A and the low switch of leg B. With polarity 0 it closes the high switch of leg B and the low switch of leg A. Polarity is captured when on-time begins.
- R3: A comparator trip ends on-time only once BLANK_CYC cycles of on-time have elapsed. With the trip held high, the on-time state lasts exactly BLANK_CYC cycles, and the full diagonal is visible at the gates for BLANK_CYC−DEAD_CYC cycles.
- R4: A trip pulse that falls entirely inside the blanking interval is dropped and not held pending. On-time continues indefinitely afterwards.
- R5: In slow decay the off-time lasts `off_cycles` cycles. During it both low switches are closed and both high switches are open, and this pattern is visible for `off_cycles`−DEAD_CYC cycles.
- R6: In mixed decay the off-time starts with fast decay for F = floor(`off_cycles`·5/16) cycles, during which the diagonal opposite to the on-time diagonal is closed. The remaining `off_cycles`−F cycles are slow decay. Each visible pattern lasts its duration minus DEAD_CYC.
- R7: The high and low switches of one leg are never closed together. A switch closes only after its partner has been open for DEAD_CYC cycles. Going from on-time to fast decay opens all four gates for exactly DEAD_CYC cycles.
- R8: If `zero_cur` is high during the off-time, all four gates are open from the second clock edge after it is sampled. They stay open until the next on-time begins, even if `zero_cur` falls.
- R9: When `out_en` is 0, all four gates are 0 in the same cycle and the controller goes idle. When `out_en` returns to 1, a new on-time starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Output enable; 0 opens all gates and idles the controller |
| trip | input | 1 | Current comparator output; 1 means the trip level is reached |
| decay_mixed | input | 1 | 1 selects mixed decay, 0 slow decay; sampled at the trip |
| polarity | input | 1 | Current direction; sampled at the start of on-time |
| zero_cur | input | 1 | Winding current has reached zero |
| off_cycles | input | OFF_W | Off-time length in clock cycles (0 treated as 1) |
| gate_hi_a | output | 1 | High switch of leg A |
| gate_lo_a | output | 1 | Low switch of leg A |
| gate_hi_b | output | 1 | High switch of leg B |
| gate_lo_b | output | 1 | Low switch of leg B |

## Verification
The hardest situation to reach from the ports is a trip that is seen by the comparator input but must be forgotten because it lands inside blanking. The bench waits until the on-time diagonal first appears at the gates. That point lies DEAD_CYC+1 cycles into on-time, which is still inside the blanking window. The bench then pulses `trip` for one cycle and confirms that the diagonal stays closed for forty more cycles. Measured run lengths of every gate pattern across both polarities, both decay styles and several off-time lengths then pin the fast/slow split and the dead time to exact cycle counts.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

    localparam int NLEG       = 2;
    localparam int FAST_NUM   = 5;   // fast share = 5/16 of the off-time
    localparam int FAST_SHIFT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_FAST = 2'd2,
        ST_SLOW = 2'd3
    } chop_st_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    // index 0 = leg A, index 1 = leg B
    typedef leg_t [NLEG-1:0] bridge_t;

    function automatic logic [31:0] fast_share(input logic [31:0] n);
        return (n * 32'(FAST_NUM)) >> FAST_SHIFT;
    endfunction

endpackage

// File: rtl/chop_fsm.sv
`timescale 1ns/1ps
module chop_fsm
    import chop_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int BLANK_CYC = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             trip,
    input  logic             mixed,
    input  logic             pol,
    input  logic             zc,
    input  logic [OFF_W-1:0] off_cycles,
    output bridge_t          req,
    output chop_st_e         st_o,
    output logic             blank_busy
);

    localparam int            BW       = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC - 1);

    chop_st_e         st_q, st_d;
    logic [OFF_W-1:0] tmr_q, tmr_d;
    logic [BW-1:0]    blank_q;
    logic             pol_q, zc_q;
    logic [OFF_W-1:0] off_eff, fast_len;
    logic             in_off;

    assign off_eff  = (off_cycles == '0) ? OFF_W'(1) : off_cycles;
    assign fast_len = OFF_W'(fast_share(32'(off_eff)));
    assign in_off   = (st_q == ST_FAST) || (st_q == ST_SLOW);

    always_comb begin
        st_d  = st_q;
        tmr_d = (tmr_q != '0) ? tmr_q - OFF_W'(1) : '0;
        unique case (st_q)
            ST_IDLE: st_d = ST_ON;
            ST_ON: begin
                if (trip && blank_q == '0) begin
                    if (mixed && fast_len != '0) begin
                        st_d  = ST_FAST;
                        tmr_d = fast_len - OFF_W'(1);
                    end else begin
                        st_d  = ST_SLOW;
                        tmr_d = off_eff - OFF_W'(1);
                    end
                end
            end
            ST_FAST: begin
                if (tmr_q == '0) begin
                    st_d  = ST_SLOW;
                    tmr_d = off_eff - fast_len - OFF_W'(1);
                end
            end
            ST_SLOW: begin
                if (tmr_q == '0) st_d = ST_ON;
            end
            default: st_d = ST_IDLE;
        endcase
        if (!en) st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            tmr_q   <= '0;
            blank_q <= '0;
            pol_q   <= 1'b0;
            zc_q    <= 1'b0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
            if (st_d != st_q)
                blank_q <= BLANK_LD;
            else if (blank_q != '0)
                blank_q <= blank_q - BW'(1);
            if (st_d == ST_ON && st_q != ST_ON)
                pol_q <= pol;
            if (st_d == ST_ON || st_d == ST_IDLE)
                zc_q <= 1'b0;
            else if (zc && in_off)
                zc_q <= 1'b1;
        end
    end

    always_comb begin
        req = '0;
        unique case (st_q)
            ST_ON: begin
                req[0].hi = pol_q;
                req[1].lo = pol_q;
                req[1].hi = !pol_q;
                req[0].lo = !pol_q;
            end
            ST_FAST: begin
                req[1].hi = pol_q;
                req[0].lo = pol_q;
                req[0].hi = !pol_q;
                req[1].lo = !pol_q;
            end
            ST_SLOW: begin
                req[0].lo = 1'b1;
                req[1].lo = 1'b1;
            end
            default: req = '0;
        endcase
        if (zc_q) req = '0;
    end

    assign st_o       = st_q;
    assign blank_busy = (blank_q != '0);

endmodule

// File: rtl/chop_leg.sv
`timescale 1ns/1ps
module chop_leg
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 95
) (
    input  logic clk,
    input  logic rst,
    input  leg_t req,
    output leg_t drv
);

    localparam int            GW      = $clog2(DEAD_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(DEAD_CYC);
    localparam logic [GW-1:0] GAP_OK  = GW'(DEAD_CYC - 1);

    // cycles for which each switch has been open, saturating
    logic [GW-1:0] hi_gap, lo_gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv    <= '0;
            hi_gap <= GAP_MAX;
            lo_gap <= GAP_MAX;
        end else begin
            drv.hi <= req.hi && !drv.lo && (lo_gap >= GAP_OK);
            drv.lo <= req.lo && !drv.hi && (hi_gap >= GAP_OK);
            hi_gap <= drv.hi ? '0 : ((hi_gap == GAP_MAX) ? GAP_MAX : hi_gap + GW'(1));
            lo_gap <= drv.lo ? '0 : ((lo_gap == GAP_MAX) ? GAP_MAX : lo_gap + GW'(1));
        end
    end

endmodule

// File: rtl/chop_ctrl.sv
`timescale 1ns/1ps
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int BLANK_CYC = 200,
    parameter int DEAD_CYC  = 95
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_en,
    input  logic             trip,
    input  logic             decay_mixed,
    input  logic             polarity,
    input  logic             zero_cur,
    input  logic [OFF_W-1:0] off_cycles,
    output logic             gate_hi_a,
    output logic             gate_lo_a,
    output logic             gate_hi_b,
    output logic             gate_lo_b
);

    bridge_t  req, drv;
    chop_st_e fsm_st;
    logic     blank_busy;

    chop_fsm #(.OFF_W(OFF_W), .BLANK_CYC(BLANK_CYC)) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (out_en),
        .trip       (trip),
        .mixed      (decay_mixed),
        .pol        (polarity),
        .zc         (zero_cur),
        .off_cycles (off_cycles),
        .req        (req),
        .st_o       (fsm_st),
        .blank_busy (blank_busy)
    );

    for (genvar gi = 0; gi < NLEG; gi++) begin : g_leg
        chop_leg #(.DEAD_CYC(DEAD_CYC)) i_leg (
            .clk (clk),
            .rst (rst),
            .req (req[gi]),
            .drv (drv[gi])
        );
    end

    assign gate_hi_a = drv[0].hi & out_en;
    assign gate_lo_a = drv[0].lo & out_en;
    assign gate_hi_b = drv[1].hi & out_en;
    assign gate_lo_b = drv[1].lo & out_en;

endmodule

// File: rtl/chop_ctrl_chk.sv
`timescale 1ns/1ps
module chop_ctrl_chk
    import chop_pkg::*;
#(
    parameter int DEAD = 95
) (
    input logic     clk,
    input logic     rst,
    input logic     en,
    input logic     hi_a,
    input logic     lo_a,
    input logic     hi_b,
    input logic     lo_b,
    input chop_st_e st,
    input logic     blank_busy
);

    logic [15:0] off_hi_a, off_lo_a, off_hi_b, off_lo_b;

    function automatic logic [15:0] bump(input logic on, input logic [15:0] c);
        if (on) return '0;
        return (c >= 16'(DEAD)) ? 16'(DEAD) : c + 16'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            off_hi_a <= 16'(DEAD);
            off_lo_a <= 16'(DEAD);
            off_hi_b <= 16'(DEAD);
            off_lo_b <= 16'(DEAD);
        end else begin
            off_hi_a <= bump(hi_a, off_hi_a);
            off_lo_a <= bump(lo_a, off_lo_a);
            off_hi_b <= bump(hi_b, off_hi_b);
            off_lo_b <= bump(lo_b, off_lo_b);
        end
    end

    a_r7_leg_a_exclusive: assert property (@(posedge clk) disable iff (rst) !(hi_a && lo_a));
    a_r7_leg_b_exclusive: assert property (@(posedge clk) disable iff (rst) !(hi_b && lo_b));
    a_r7_dead_hi_a: assert property (@(posedge clk) disable iff (rst) $rose(hi_a) |-> off_lo_a >= 16'(DEAD));
    a_r7_dead_lo_a: assert property (@(posedge clk) disable iff (rst) $rose(lo_a) |-> off_hi_a >= 16'(DEAD));
    a_r7_dead_hi_b: assert property (@(posedge clk) disable iff (rst) $rose(hi_b) |-> off_lo_b >= 16'(DEAD));
    a_r7_dead_lo_b: assert property (@(posedge clk) disable iff (rst) $rose(lo_b) |-> off_hi_b >= 16'(DEAD));
    a_r2_single_high: assert property (@(posedge clk) disable iff (rst) !(hi_a && hi_b));
    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (rst) !en |=> st == ST_IDLE);
    a_r3_blank_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ON && blank_busy && en) |=> st == ST_ON);
    a_r6_fast_then_slow: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAST && en) |=> (st == ST_FAST || st == ST_SLOW));

endmodule

bind chop_ctrl chop_ctrl_chk #(.DEAD(DEAD_CYC)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (out_en),
    .hi_a       (gate_hi_a),
    .lo_a       (gate_lo_a),
    .hi_b       (gate_hi_b),
    .lo_b       (gate_lo_b),
    .st         (fsm_st),
    .blank_busy (blank_busy)
);

// File: tb/test_chop_ctrl.sv
`timescale 1ns/1ps
module test_chop_ctrl;

    localparam int BL = 6;
    localparam int DT = 2;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b1, trip = 1'b0, mixed = 1'b0, pol = 1'b1, zc = 1'b0;
    logic [OW-1:0] offc = 16'd20;
    logic          hia, loa, hib, lob;
    logic [3:0]    g;
    int            checks = 0, errs = 0, shoot = 0;

    assign g = {hia, loa, hib, lob};

    always #2.5 clk = ~clk;

    chop_ctrl #(.OFF_W(OW), .BLANK_CYC(BL), .DEAD_CYC(DT)) i_chop_ctrl (
        .clk(clk), .rst(rst), .out_en(en), .trip(trip), .decay_mixed(mixed),
        .polarity(pol), .zero_cur(zc), .off_cycles(offc),
        .gate_hi_a(hia), .gate_lo_a(loa), .gate_hi_b(hib), .gate_lo_b(lob)
    );

    always @(negedge clk) if (!rst && ((hia && loa) || (hib && lob))) shoot++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pat(input logic [3:0] p, output bit found);
        found = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (g == p) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_len(input logic [3:0] p, output int n);
        n = 0;
        while (g == p && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input bit p, input bit m, input int t);
        logic [3:0] on_p, fa_p, sl_p;
        bit f;
        int n, fl;
        on_p = p ? 4'b1001 : 4'b0110;
        fa_p = p ? 4'b0110 : 4'b1001;
        sl_p = 4'b0101;
        fl   = (t * 5) / 16;
        pol = p; mixed = m; offc = OW'(t); trip = 1'b1;
        wait_pat(sl_p, f);
        wait_pat(on_p, f);
        chk(f, "R2 on-time diagonal", int'(g), int'(on_p));
        run_len(on_p, n);
        chk(n == BL - DT, "R3 on-time length with trip held", n, BL - DT);
        if (m) begin
            run_len(4'b0000, n);
            chk(n == DT, "R7 dead gap on-time to fast", n, DT);
            chk(g == fa_p, "R6 fast diagonal", int'(g), int'(fa_p));
            run_len(fa_p, n);
            chk(n == fl - DT, "R6 fast length", n, fl - DT);
            wait_pat(sl_p, f);
            run_len(sl_p, n);
            chk(n == t - fl - DT, "R6 slow remainder", n, t - fl - DT);
        end else begin
            wait_pat(sl_p, f);
            chk(f, "R5 slow pattern", int'(g), int'(sl_p));
            run_len(sl_p, n);
            chk(n == t - DT, "R5 slow length", n, t - DT);
        end
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin : main
        bit f;
        int lens[3];
        lens[0] = 16; lens[1] = 23; lens[2] = 40;
        repeat (3) @(negedge clk);
        chk(g == 4'b0000, "R1 gates off in reset", int'(g), 0);
        rst = 1'b0;

        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 2; m++)
                for (int k = 0; k < 3; k++)
                    measure(p[0], m[0], lens[k]);

        // R4: trip pulse inside blanking is dropped
        pol = 1'b1; mixed = 1'b0; offc = 16'd20; trip = 1'b1;
        wait_pat(4'b0101, f);
        trip = 1'b0;
        wait_pat(4'b1001, f);
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        repeat (40) @(negedge clk);
        chk(g == 4'b1001, "R4 on-time continues after blanked trip", int'(g), 9);
        trip = 1'b1;
        wait_pat(4'b0101, f);
        chk(f, "R3 trip after blanking ends on-time", int'(g), 5);

        // R8: zero current opens all gates until next on-time
        offc = 16'd40;
        wait_pat(4'b1001, f);
        wait_pat(4'b0101, f);
        zc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(g == 4'b0000, "R8 gates open on zero current", int'(g), 0);
        zc = 1'b0;
        repeat (5) @(negedge clk);
        chk(g == 4'b0000, "R8 stays open after zero_cur falls", int'(g), 0);
        wait_pat(4'b1001, f);
        chk(f, "R8 on-time resumes", int'(g), 9);

        // R9: output enable
        wait_pat(4'b1001, f);
        en = 1'b0;
        #1;
        chk(g == 4'b0000, "R9 gates open same cycle", int'(g), 0);
        repeat (4) @(negedge clk);
        chk(g == 4'b0000, "R9 gates stay open while disabled", int'(g), 0);
        en = 1'b1;
        wait_pat(4'b1001, f);
        chk(f, "R9 on-time restarts after enable", int'(g), 9);

        chk(shoot == 0, "R7 no shoot-through", shoot, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule